// File: doc/BRIEF.md
# Page Entry Access Checker

This block judges one memory access against one page table entry. Each request carries the entry, whether the access is a load or a store, and whether it comes from user or kernel mode. One clock later the block reports a result. The result is either a single fault code, or a grant that carries the physical frame number, the uncached attribute and the entry with its usage bits brought up to date.

When the usage bits change, a flag tells the surrounding translation logic that the entry has to be written back to the page table. The block does not fetch entries, hold translations or handle faults. It only decides and updates.

The entry layout is fixed by the package. Bit 0 is present. Bit 1 is write-protect. Bit 2 is kernel-only. Bit 3 is referenced. Bit 4 is modified. Bit 5 is uncached. Bits FRAME_W+5 down to 6 hold the frame number. The fault code is 0 for none, 1 for page not present, 2 for privilege violation and 3 for write-protection violation.

A small result state machine holds the outcome of the last request. It has three states: ST_IDLE (no result this cycle), ST_GRANT (a permitted access is being reported) and ST_FAULT (a rejected access is being reported). From any state, a cycle with `req_valid` high moves to ST_GRANT or ST_FAULT according to the check. A cycle with `req_valid` low moves to ST_IDLE. Reset enters ST_IDLE.

Top module: `pte_perm_check`

## Requirements
- R1: During and right after reset, `rsp_valid` is 0 and `rsp_fault`, `rsp_frame`, `rsp_uncached`, `rsp_entry` and `rsp_writeback` are all 0.
- R2: `rsp_valid` is 1 in the cycle after each cycle where `req_valid` is 1, and 0 in the cycle after each cycle where it is 0. All outputs belong to the request sampled at that edge.
- R3: If the present bit (bit 0) is 0, the fault code is 1, whatever the other bits, the access type and the mode are.
- R4: If the entry is present, the kernel-only bit (bit 2) is 1 and the access is from user mode, the fault code is 2, even for a store to a write-protected page.
- R5: If the entry is present, no privilege fault applies, the write-protect bit (bit 1) is 1 and the access is a store, the fault code is 3. A load to such a page is granted with code 0.
- R6: A granted access of either type returns the entry with the referenced bit (bit 3) set to 1.
- R7: A granted store returns the entry with the modified bit (bit 4) set to 1. A granted load returns the modified bit unchanged.
- R8: `rsp_writeback` is 1 only for a granted access whose referenced or modified bit differs from the incoming entry. Otherwise it is 0.
- R9: A faulting access returns the incoming entry unchanged, `rsp_writeback` 0, `rsp_frame` 0 and `rsp_uncached` 0.
- R10: A granted access returns the frame number from bits FRAME_W+5..6 on `rsp_frame` and bit 5 on `rsp_uncached`. Every entry bit other than bits 3 and 4 is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; the inputs below are sampled when high |
| req_entry | input | FRAME_W+6 | Page table entry under test |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_user | input | 1 | 1 for user mode, 0 for kernel mode |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_fault | output | 2 | Fault code (0 none, 1 not present, 2 privilege, 3 write-protect) |
| rsp_frame | output | FRAME_W | Physical frame number on a grant |
| rsp_uncached | output | 1 | Cache-bypass attribute on a grant |
| rsp_entry | output | FRAME_W+6 | Updated entry on a grant, original entry on a fault |
| rsp_writeback | output | 1 | Updated entry must be stored back |

## Verification
Random entries, access types and modes are mixed so that every combination of the present, kernel-only and write-protect bits is met. This tells apart the three fault codes and their priority. Random initial referenced and modified bits show whether the write-back flag follows a real change or merely follows a grant.

Directed corners cover several cases:
- An all-ones entry stored from user mode, which separates privilege from write-protect.
- A write-protected page loaded from kernel mode.
- An already referenced and modified entry, which must not raise a write-back.
- A non-present entry with every other bit set.

Idle gaps between requests show that a result is reported exactly once.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

    localparam int PTE_FLAG_W = 6;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WPROT   = 1;
    localparam int BIT_KERNEL  = 2;
    localparam int BIT_REF     = 3;
    localparam int BIT_MOD     = 4;
    localparam int BIT_NOCACHE = 5;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_PRIV    = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_code_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_FAULT = 2'd2
    } chk_state_t;

endpackage

// File: rtl/pte_fault_judge.sv
module pte_fault_judge
    import pte_chk_pkg::*;
(
    input  logic        present,
    input  logic        wprot,
    input  logic        kernel_only,
    input  logic        is_store,
    input  logic        is_user,
    output fault_code_t fault
);

    logic hit_absent;
    logic hit_priv;
    logic hit_wprot;

    always_comb begin
        hit_absent = !present;
        hit_priv   = kernel_only && is_user;
        hit_wprot  = wprot && is_store;
    end

    // Priority: absence beats privilege, privilege beats write-protect.
    always_comb begin
        if (hit_absent)
            fault = FLT_ABSENT;
        else if (hit_priv)
            fault = FLT_PRIV;
        else if (hit_wprot)
            fault = FLT_WPROT;
        else
            fault = FLT_NONE;
    end

    // A reported write-protect fault must never hide a privilege or absence cause (R4, R3).
    always_comb begin
        assert_no_masked_cause_R4: assert (!(fault == FLT_WPROT) || (present && !(kernel_only && is_user)))
            else $error("write-protect fault reported over a higher cause");
    end

endmodule

// File: rtl/pte_bit_update.sv
module pte_bit_update
    import pte_chk_pkg::*;
#(
    parameter int PTE_W = 26
) (
    input  logic [PTE_W-1:0] entry_in,
    input  logic             is_store,
    output logic [PTE_W-1:0] entry_out,
    output logic             changed
);

    logic ref_next;
    logic mod_next;

    always_comb begin
        ref_next = 1'b1;
        mod_next = entry_in[BIT_MOD] | is_store;
    end

    always_comb begin
        entry_out          = entry_in;
        entry_out[BIT_REF] = ref_next;
        entry_out[BIT_MOD] = mod_next;
        changed            = (ref_next != entry_in[BIT_REF]) || (mod_next != entry_in[BIT_MOD]);
    end

    // Only the two usage bits may move (R10).
    always_comb begin
        assert_only_usage_bits_R10: assert ((entry_out ^ entry_in) ==
                ((entry_out ^ entry_in) & ((PTE_W'(1) << BIT_REF) | (PTE_W'(1) << BIT_MOD))))
            else $error("non-usage bit altered");
    end

endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
    import pte_chk_pkg::*;
#(
    parameter  int FRAME_W = 20,
    localparam int PTE_W   = FRAME_W + PTE_FLAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PTE_W-1:0]   req_entry,
    input  logic               req_store,
    input  logic               req_user,
    output logic               rsp_valid,
    output logic [1:0]         rsp_fault,
    output logic [FRAME_W-1:0] rsp_frame,
    output logic               rsp_uncached,
    output logic [PTE_W-1:0]   rsp_entry,
    output logic               rsp_writeback
);

    fault_code_t      judge_fault;
    logic [PTE_W-1:0] upd_entry;
    logic             upd_changed;
    chk_state_t       state_q;
    chk_state_t       state_d;
    logic [PTE_W-1:0] ent_q;
    fault_code_t      fault_q;
    logic             wb_q;

    pte_fault_judge u_judge (
        .present     (req_entry[BIT_PRESENT]),
        .wprot       (req_entry[BIT_WPROT]),
        .kernel_only (req_entry[BIT_KERNEL]),
        .is_store    (req_store),
        .is_user     (req_user),
        .fault       (judge_fault)
    );

    pte_bit_update #(.PTE_W(PTE_W)) u_update (
        .entry_in  (req_entry),
        .is_store  (req_store),
        .entry_out (upd_entry),
        .changed   (upd_changed)
    );

    // Next state
    always_comb begin
        if (!req_valid)
            state_d = ST_IDLE;
        else if (judge_fault == FLT_NONE)
            state_d = ST_GRANT;
        else
            state_d = ST_FAULT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Result holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q   <= '0;
            fault_q <= FLT_NONE;
            wb_q    <= 1'b0;
        end else if (req_valid) begin
            ent_q   <= (judge_fault == FLT_NONE) ? upd_entry : req_entry;
            fault_q <= judge_fault;
            wb_q    <= (judge_fault == FLT_NONE) && upd_changed;
        end
    end

    // Outputs per state
    always_comb begin
        rsp_valid     = 1'b0;
        rsp_fault     = FLT_NONE;
        rsp_frame     = '0;
        rsp_uncached  = 1'b0;
        rsp_entry     = '0;
        rsp_writeback = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_GRANT: begin
                rsp_valid     = 1'b1;
                rsp_frame     = ent_q[PTE_W-1:PTE_FLAG_W];
                rsp_uncached  = ent_q[BIT_NOCACHE];
                rsp_entry     = ent_q;
                rsp_writeback = wb_q;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = fault_q;
                rsp_entry = ent_q;
            end
            default: begin
            end
        endcase
    end

    // Clocked checks
    assert_result_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("missing result");

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("result without request");

    assert_fault_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (!rsp_writeback && rsp_frame == '0 && !rsp_uncached))
        else $error("fault carries grant data");

    assert_wb_only_on_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_writeback |-> (rsp_valid && rsp_fault == FLT_NONE))
        else $error("write-back outside a grant");

    assert_grant_refs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_entry[BIT_REF])
        else $error("granted entry not referenced");

    assert_store_dirties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && judge_fault == FLT_NONE) |=> rsp_entry[BIT_MOD])
        else $error("granted store not marked modified");

    assert_absent_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_entry[BIT_PRESENT]) |=> (rsp_fault == FLT_ABSENT))
        else $error("absent entry not reported");

    assert_user_kernel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_entry[BIT_PRESENT] && req_entry[BIT_KERNEL] && req_user) |=> (rsp_fault == FLT_PRIV))
        else $error("privilege violation not reported");

endmodule

// File: tb/sim_pte_perm_check.sv
`timescale 1ns/1ps
module sim_pte_perm_check;

    localparam int FW = 20;
    localparam int EW = FW + 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [EW-1:0] req_entry = '0;
    logic          req_store = 1'b0;
    logic          req_user = 1'b0;
    logic          rsp_valid;
    logic [1:0]    rsp_fault;
    logic [FW-1:0] rsp_frame;
    logic          rsp_uncached;
    logic [EW-1:0] rsp_entry;
    logic          rsp_writeback;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pte_perm_check #(.FRAME_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_entry(req_entry),
        .req_store(req_store), .req_user(req_user), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_frame(rsp_frame), .rsp_uncached(rsp_uncached),
        .rsp_entry(rsp_entry), .rsp_writeback(rsp_writeback)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [EW-1:0] e, input logic st, input logic us);
        if (!e[0]) return 2'd1;
        if (e[2] && us) return 2'd2;
        if (e[1] && st) return 2'd3;
        return 2'd0;
    endfunction

    // Drive at a falling edge, check at the next falling edge
    task automatic apply(input logic [EW-1:0] e, input logic st, input logic us);
        logic [1:0]    f;
        logic [EW-1:0] ne;
        logic          wb;
        string         ftag;
        req_valid = 1'b1; req_entry = e; req_store = st; req_user = us;
        f  = exp_fault(e, st, us);
        ne = e;
        wb = 1'b0;
        if (f == 2'd0) begin
            ne[3] = 1'b1;
            if (st) ne[4] = 1'b1;
            wb = (ne[3] != e[3]) || (ne[4] != e[4]);
        end
        @(negedge clk);
        case (f)
            2'd1: ftag = "R3 fault";
            2'd2: ftag = "R4 fault";
            2'd3: ftag = "R5 fault";
            default: ftag = (e[1] && !st) ? "R5 wp-load fault" : "R10 fault";
        endcase
        chk("R2 valid", 64'(rsp_valid), 64'd1);
        chk(ftag, 64'(rsp_fault), 64'(f));
        if (f != 2'd0) begin
            chk("R9 entry", 64'(rsp_entry), 64'(e));
            chk("R9 frame", 64'(rsp_frame), 64'd0);
            chk("R9 uncached", 64'(rsp_uncached), 64'd0);
        end else begin
            chk(st ? "R7 entry" : "R6 entry", 64'(rsp_entry), 64'(ne));
            chk("R10 frame", 64'(rsp_frame), 64'(e[EW-1:6]));
            chk("R10 uncached", 64'(rsp_uncached), 64'(e[5]));
        end
        chk("R8 writeback", 64'(rsp_writeback), 64'(wb));
    endtask

    task automatic idle_one();
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle valid", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [EW-1:0] e;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", 64'(rsp_valid), 64'd0);
        chk("R1 fault", 64'(rsp_fault), 64'd0);
        chk("R1 frame", 64'(rsp_frame), 64'd0);
        chk("R1 uncached", 64'(rsp_uncached), 64'd0);
        chk("R1 entry", 64'(rsp_entry), 64'd0);
        chk("R1 writeback", 64'(rsp_writeback), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'(rsp_valid), 64'd0);

        // Directed corners
        apply({EW{1'b1}}, 1'b1, 1'b1);              // R4 over write-protect
        apply({EW{1'b1}}, 1'b1, 1'b0);              // R5 kernel store on wp
        apply({EW{1'b1}}, 1'b0, 1'b0);              // granted load, no write-back (R8)
        apply({{(EW-1){1'b1}}, 1'b0}, 1'b1, 1'b1);  // R3 absent with all else set
        idle_one();
        apply(EW'(32'h000A_B001), 1'b1, 1'b1);      // user store, clean entry: R7
        apply(EW'(32'h000A_B00B), 1'b0, 1'b1);      // wp load, referenced already
        idle_one();
        idle_one();

        // Random mix
        for (int i = 0; i < 400; i++) begin
            e = EW'({$urandom, $urandom});
            if ($urandom_range(3, 0) != 0) e[0] = 1'b1;
            apply(e, 1'($urandom), 1'($urandom));
            if ($urandom_range(7, 0) == 0) idle_one();
        end
        idle_one();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule